// File: doc/BRIEF.md
# Operand Bus Cycle Sequencer

This block is the bus-master sequencer for one transfer on the operand bus, used once bus ownership has been won elsewhere. A requester presents a transfer kind (memory or I/O space, read or write, operand or instruction fetch), a 16-bit address and, for writes, the data. The sequencer then drives the active-low address strobe and data strobe, the type and direction qualifiers and the output enables for the address, control and data lines. It holds the data phase open until the slave pulls the active-low acknowledge low, or until a memory-protect or bus-timeout error input ends the cycle.

All timing is in half bus clocks. The block runs on a clock at twice the bus rate; one period of `clk` is called a tick. An internal phase bit alternates every tick: the first tick after reset is a rising half, the next a falling half, and so on. A cycle always starts in a rising half. When the cycle ends, the block returns the read data and an error code with a one-tick done pulse. Tri-state is modelled by enable outputs. The bus-owned indicator `own_n_o` and the address and control lines float when `bus_oe_o` is low. The data lines float when `data_oe_o` is low.

States: IDLE (bus released), ADDR (address phase, one tick), LEAD (first half of the wait phase, data strobe still high), STROBE and SAMPLE (wait phase; the step from SAMPLE samples acknowledge and errors), TAIL (half clock after termination), HOLD (strobes still low), RELEASE (strobes high, lines still driven). Transitions: IDLE→ADDR when a request is present at the end of a falling-half tick. ADDR→LEAD→STROBE→SAMPLE in turn. SAMPLE→TAIL when the cycle terminates, otherwise SAMPLE→STROBE. TAIL→HOLD→RELEASE→IDLE in turn.

Top module: `opbus_cycle_seq`

## Requirements
- R1: While reset is low, and on the first tick after it, `as_n_o` and `ds_n_o` are high, `bus_oe_o`, `data_oe_o` and `done_o` are low, and `own_n_o` is high.
- R2: A request is taken when `req_i` is high at the end of a falling-half tick while idle. In the following tick `as_n_o` and `own_n_o` go low and `bus_oe_o` goes high. `bus_addr_o`, `bus_wr_o` (1 = write), `bus_mem_o` (1 = memory, 0 = I/O) and `bus_opnd_o` (1 = operand) carry the request and stay unchanged while `bus_oe_o` is high.
- R3: `ds_n_o` falls exactly two ticks after `as_n_o` falls, and is never low while `as_n_o` is high.
- R4: Acknowledge and both error inputs are sampled only at the end of falling-half ticks in which `ds_n_o` was already low in the tick before. The data strobe stays low, for any number of ticks, until such a sample sees `ack_n_i` low or an error high.
- R5: `err_o` reports 0 for a clean finish, 1 when `prot_i` was high at the terminating sample and 2 when only `tmo_i` was high. An error terminates the cycle even while `ack_n_i` stays high, and protect wins when both errors are high.
- R6: `done_o` is high for exactly the one tick after the terminating sample. In that tick `rdata_o` holds `bus_rdata_i` as sampled at the terminating edge, and `err_o` holds the code.
- R7: Both strobes stay low for two ticks after the terminating sample and return high together in the third tick.
- R8: `bus_oe_o` drops, and `own_n_o` goes high, one tick after the strobes return high. No other cycle may begin before then.
- R9: `data_oe_o` is high only while `bus_oe_o` is high in a write cycle, and it is never high in a read cycle.
- R10: All four transfer kinds (memory read, memory write, I/O read, I/O write) follow the same strobe timing. Only the qualifier outputs differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock, one tick per half bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Transfer request, held until the address strobe falls |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_opnd_i | input | 1 | 1 = operand transfer, 0 = instruction |
| req_addr_i | input | 16 | Transfer address |
| req_wdata_i | input | 16 | Write data |
| ack_n_i | input | 1 | Active-low slave acknowledge |
| prot_i | input | 1 | Memory-protect error |
| tmo_i | input | 1 | Bus-timeout error |
| bus_rdata_i | input | 16 | Data lines from the bus |
| as_n_o | output | 1 | Active-low address strobe |
| ds_n_o | output | 1 | Active-low data strobe |
| own_n_o | output | 1 | Active-low bus-owned indicator, floated when bus_oe_o is low |
| bus_oe_o | output | 1 | Enable for address, qualifiers and own_n_o |
| data_oe_o | output | 1 | Enable for write data lines |
| bus_addr_o | output | 16 | Address lines |
| bus_wdata_o | output | 16 | Write data lines |
| bus_wr_o | output | 1 | Direction qualifier |
| bus_mem_o | output | 1 | Memory/I-O qualifier |
| bus_opnd_o | output | 1 | Operand/instruction qualifier |
| done_o | output | 1 | One-tick completion pulse |
| err_o | output | 2 | Completion code 0/1/2 |
| rdata_o | output | 16 | Captured read data |

## Verification
A wrong state in the sequencer shows up directly on the strobes and enables. A skipped or repeated state moves the fall of `ds_n_o`, the rise of the strobes or the drop of `bus_oe_o` by at least one tick. A wrong sampling edge makes the wait phase one tick longer or shorter than an acknowledge at a known tick allows. The bench's model predicts every strobe, enable and done value for every tick, so any such slip is seen within the tick it happens. Wrong captured data or a wrong error priority shows up in the single done tick.

// File: rtl/opbus_cycle_pkg.sv
package opbus_cycle_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_LEAD    = 3'd2,
        ST_STROBE  = 3'd3,
        ST_SAMPLE  = 3'd4,
        ST_TAIL    = 3'd5,
        ST_HOLD    = 3'd6,
        ST_RELEASE = 3'd7
    } seq_state_e;

    typedef enum logic [1:0] {
        CODE_NONE = 2'd0,
        CODE_PROT = 2'd1,
        CODE_TMO  = 2'd2
    } seq_code_e;

    typedef struct packed {
        logic mem;
        logic wr;
        logic opnd;
    } xfer_kind_t;

endpackage

// File: rtl/opbus_phase.sv
module opbus_phase (
    input  logic clk,
    input  logic rst_n,
    output logic last_half_o
);
    // 0 = rising half tick, 1 = falling half tick
    logic half_q;

    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= ~half_q;
    end

    assign last_half_o = half_q;
endmodule

// File: rtl/opbus_seq_fsm.sv
module opbus_seq_fsm
    import opbus_cycle_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_i,
    input  logic       last_half_i,
    input  logic       finish_i,
    output logic       launch_o,
    output logic       capture_o,
    output logic       as_n_o,
    output logic       ds_n_o,
    output logic       drive_o
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_i && last_half_i) state_d = ST_ADDR;
            ST_ADDR:    state_d = ST_LEAD;
            ST_LEAD:    state_d = ST_STROBE;
            ST_STROBE:  state_d = ST_SAMPLE;
            ST_SAMPLE:  state_d = finish_i ? ST_TAIL : ST_STROBE;
            ST_TAIL:    state_d = ST_HOLD;
            ST_HOLD:    state_d = ST_RELEASE;
            ST_RELEASE: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        launch_o  = 1'b0;
        capture_o = 1'b0;
        as_n_o    = 1'b1;
        ds_n_o    = 1'b1;
        drive_o   = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                drive_o  = 1'b0;
                launch_o = req_i && last_half_i;
            end
            ST_ADDR, ST_LEAD: as_n_o = 1'b0;
            ST_STROBE: begin
                as_n_o = 1'b0;
                ds_n_o = 1'b0;
            end
            ST_SAMPLE: begin
                as_n_o    = 1'b0;
                ds_n_o    = 1'b0;
                capture_o = finish_i;
            end
            ST_TAIL, ST_HOLD: begin
                as_n_o = 1'b0;
                ds_n_o = 1'b0;
            end
            ST_RELEASE: ;
        endcase
    end
endmodule

// File: rtl/opbus_seq_data.sv
module opbus_seq_data
    import opbus_cycle_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          capture_i,
    input  xfer_kind_t    kind_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic          prot_i,
    input  logic          tmo_i,
    input  logic [DW-1:0] rdata_i,
    output xfer_kind_t    kind_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] wdata_o,
    output logic          done_o,
    output logic [1:0]    code_o,
    output logic [DW-1:0] rdata_o
);
    xfer_kind_t    kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q;
    logic          done_q;
    seq_code_e     code_q, code_d;

    // protect outranks timeout
    always_comb begin
        if (prot_i)     code_d = CODE_PROT;
        else if (tmo_i) code_d = CODE_TMO;
        else            code_d = CODE_NONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (launch_i) begin
            kind_q  <= kind_i;
            addr_q  <= addr_i;
            wdata_q <= wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q  <= 1'b0;
            code_q  <= CODE_NONE;
            rdata_q <= '0;
        end else begin
            done_q <= capture_i;
            if (capture_i) begin
                code_q  <= code_d;
                rdata_q <= rdata_i;
            end
        end
    end

    assign kind_o  = kind_q;
    assign addr_o  = addr_q;
    assign wdata_o = wdata_q;
    assign done_o  = done_q;
    assign code_o  = code_q;
    assign rdata_o = rdata_q;
endmodule

// File: rtl/opbus_cycle_seq.sv
module opbus_cycle_seq
    import opbus_cycle_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic          req_mem_i,
    input  logic          req_wr_i,
    input  logic          req_opnd_i,
    input  logic [AW-1:0] req_addr_i,
    input  logic [DW-1:0] req_wdata_i,
    input  logic          ack_n_i,
    input  logic          prot_i,
    input  logic          tmo_i,
    input  logic [DW-1:0] bus_rdata_i,
    output logic          as_n_o,
    output logic          ds_n_o,
    output logic          own_n_o,
    output logic          bus_oe_o,
    output logic          data_oe_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [DW-1:0] bus_wdata_o,
    output logic          bus_wr_o,
    output logic          bus_mem_o,
    output logic          bus_opnd_o,
    output logic          done_o,
    output logic [1:0]    err_o,
    output logic [DW-1:0] rdata_o
);
    logic       last_half, finish, launch, capture, drive;
    xfer_kind_t kind_in, kind_cur;

    assign finish  = !ack_n_i || prot_i || tmo_i;
    assign kind_in = '{mem: req_mem_i, wr: req_wr_i, opnd: req_opnd_i};

    opbus_phase u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .last_half_o (last_half)
    );

    opbus_seq_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .last_half_i (last_half),
        .finish_i    (finish),
        .launch_o    (launch),
        .capture_o   (capture),
        .as_n_o      (as_n_o),
        .ds_n_o      (ds_n_o),
        .drive_o     (drive)
    );

    opbus_seq_data #(.AW(AW), .DW(DW)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .capture_i (capture),
        .kind_i    (kind_in),
        .addr_i    (req_addr_i),
        .wdata_i   (req_wdata_i),
        .prot_i    (prot_i),
        .tmo_i     (tmo_i),
        .rdata_i   (bus_rdata_i),
        .kind_o    (kind_cur),
        .addr_o    (bus_addr_o),
        .wdata_o   (bus_wdata_o),
        .done_o    (done_o),
        .code_o    (err_o),
        .rdata_o   (rdata_o)
    );

    assign bus_oe_o   = drive;
    assign own_n_o    = !drive;
    assign data_oe_o  = drive && kind_cur.wr;
    assign bus_wr_o   = kind_cur.wr;
    assign bus_mem_o  = kind_cur.mem;
    assign bus_opnd_o = kind_cur.opnd;
endmodule

// File: rtl/opbus_cycle_seq_chk.sv
module opbus_cycle_seq_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          as_n_o,
    input logic          ds_n_o,
    input logic          bus_oe_o,
    input logic          data_oe_o,
    input logic          bus_wr_o,
    input logic          bus_mem_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          done_o,
    input logic [1:0]    err_o
);
    assert_ds_inside_as_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ds_n_o |-> !as_n_o);

    assert_lead_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(as_n_o) |=> (!as_n_o && ds_n_o));

    assert_strobe_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n_o) |-> $past(!as_n_o, 2));

    assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_o && $past(bus_oe_o)) |-> ($stable(bus_addr_o) && $stable(bus_wr_o) && $stable(bus_mem_o)));

    assert_release_driven_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n_o) |-> bus_oe_o);

    assert_float_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(as_n_o) |=> !bus_oe_o);

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_code_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (err_o != 2'd3));

    assert_write_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe_o |-> (bus_oe_o && bus_wr_o));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe_o |-> (as_n_o && ds_n_o));
endmodule

bind opbus_cycle_seq opbus_cycle_seq_chk #(.AW(AW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .as_n_o     (as_n_o),
    .ds_n_o     (ds_n_o),
    .bus_oe_o   (bus_oe_o),
    .data_oe_o  (data_oe_o),
    .bus_wr_o   (bus_wr_o),
    .bus_mem_o  (bus_mem_o),
    .bus_addr_o (bus_addr_o),
    .done_o     (done_o),
    .err_o      (err_o)
);

// File: tb/opbus_cycle_seq_tb_top.sv
`timescale 1ns/1ps
module opbus_cycle_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, r_mem = 1'b0, r_wr = 1'b0, r_opnd = 1'b0;
    logic [15:0] r_addr = '0, r_wdata = '0, rd_in = '0;
    logic        ack_n = 1'b1, prot = 1'b0, tmo = 1'b0;
    logic        as_n, ds_n, own_n, oe, doe, b_wr, b_mem, b_opnd, done;
    logic [15:0] b_addr, b_wdata, rdata;
    logic [1:0]  err;

    int n_checks = 0, n_fail = 0;

    always #2 clk = ~clk;

    opbus_cycle_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .req_mem_i(r_mem), .req_wr_i(r_wr),
        .req_opnd_i(r_opnd), .req_addr_i(r_addr), .req_wdata_i(r_wdata),
        .ack_n_i(ack_n), .prot_i(prot), .tmo_i(tmo), .bus_rdata_i(rd_in),
        .as_n_o(as_n), .ds_n_o(ds_n), .own_n_o(own_n), .bus_oe_o(oe), .data_oe_o(doe),
        .bus_addr_o(b_addr), .bus_wdata_o(b_wdata), .bus_wr_o(b_wr), .bus_mem_o(b_mem),
        .bus_opnd_o(b_opnd), .done_o(done), .err_o(err), .rdata_o(rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising clk edge
    bit          m_half = 0, m_run = 0;
    int          m_k = 0, m_term = -1;
    logic        m_wr = 0, m_mem = 0, m_opnd = 0;
    logic [15:0] m_addr = 0, m_wdata = 0, m_rd = 0;
    logic [1:0]  m_err = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_half = 0; m_run = 0; m_k = 0; m_term = -1;
        end else begin
            if (!m_run) begin
                if (req && m_half) begin
                    m_run = 1; m_k = 0; m_term = -1;
                    m_wr = r_wr; m_mem = r_mem; m_opnd = r_opnd;
                    m_addr = r_addr; m_wdata = r_wdata;
                end
            end else begin
                if (m_term < 0 && m_k >= 3 && (m_k % 2) == 1 && (!ack_n || prot || tmo)) begin
                    m_term = m_k + 1;
                    m_err  = prot ? 2'd1 : (tmo ? 2'd2 : 2'd0);
                    m_rd   = rd_in;
                end
                if (m_term >= 0 && m_k == m_term + 2) m_run = 0;
                else m_k++;
            end
            m_half = ~m_half;
        end
    end

    // scenario controls for the responder
    int  ack_after = 1;
    bit  use_ack = 1, use_prot = 0, use_tmo = 0;
    int  ds_cnt = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            bit e_as, e_ds, e_live;
            e_live = m_run && (m_term < 0 || m_k <= m_term + 1);
            e_as = !e_live;
            e_ds = !(e_live && m_k >= 2);
            check("R2/R7 as_n", as_n, e_as);
            check("R3/R4 ds_n", ds_n, e_ds);
            check("R8 bus_oe", oe, m_run);
            check("R8 own_n", own_n, !m_run);
            check("R9 data_oe", doe, m_run && m_wr);
            check("R6 done", done, m_run && m_k == m_term);
            if (m_run) begin
                check("R2/R10 addr", b_addr, m_addr);
                check("R10 qual", {b_wr, b_mem, b_opnd}, {m_wr, m_mem, m_opnd});
                if (m_wr) check("R9 wdata", b_wdata, m_wdata);
            end
            if (done) begin
                check("R5 err", err, m_err);
                check("R6 rdata", rdata, m_rd);
            end
        end
        // responder
        if (!ds_n) ds_cnt++; else ds_cnt = 0;
        ack_n = !(use_ack && ds_cnt >= ack_after);
        prot  = use_prot && ds_cnt >= ack_after;
        tmo   = use_tmo && ds_cnt >= ack_after;
    end

    task automatic run(input bit mem, input bit wr, input bit opnd, input logic [15:0] a,
                       input int dly, input bit ak, input bit pr, input bit tm);
        @(negedge clk);
        ack_after = dly; use_ack = ak; use_prot = pr; use_tmo = tm;
        r_mem = mem; r_wr = wr; r_opnd = opnd; r_addr = a; r_wdata = a ^ 16'h5A5A;
        rd_in = a ^ 16'hC3C3;
        req = 1'b1;
        while (as_n) @(negedge clk);
        req = 1'b0;
        while (!oe) @(negedge clk);
        while (oe) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 as_n", as_n, 1'b1);
        check("R1 ds_n", ds_n, 1'b1);
        check("R1 oe", oe, 1'b0);
        check("R1 done", done, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset oe", oe, 1'b0);
        check("R1 after reset as_n", as_n, 1'b1);
        // R10: four kinds
        run(1, 0, 1, 16'h1000, 1, 1, 0, 0);
        run(1, 1, 1, 16'h2002, 3, 1, 0, 0);
        run(0, 0, 0, 16'h0030, 2, 1, 0, 0);
        run(0, 1, 1, 16'h0044, 6, 1, 0, 0);
        // R4: long stretch
        run(1, 0, 0, 16'hBEEF, 11, 1, 0, 0);
        // R5: protect only, timeout only (no ack), both
        run(1, 1, 1, 16'h0100, 2, 0, 1, 0);
        run(1, 0, 1, 16'h0200, 4, 0, 0, 1);
        run(0, 0, 1, 16'h0300, 3, 0, 1, 1);
        run(1, 0, 1, 16'h0400, 1, 1, 0, 1);
        // R8: back to back, request held early
        run(1, 1, 0, 16'hFFFF, 1, 1, 0, 0);
        run(1, 0, 0, 16'h0000, 1, 1, 0, 0);
        repeat (4) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule